// File: doc/BRIEF.md
# Double-Buffered Line Latch with External Clock Selection

This block is the second latching stage of a 24-line differential I/O port. An output word written by the host-side logic moves through a holding register into the line drivers, and the sampled line states move through an input register into the host-readable input word. With double buffering off, both registers track the system clock. The output register loads on the falling edge and the input register on the rising edge.

With double buffering on, both registers update together on one chosen edge of a slow external synchronizing clock. Two control bits set which edge is used and where the clock comes from. It can come from a dedicated single-ended pin, or from the highest-numbered I/O line when modules are chained. The external clock is brought into the system-clock domain through a configurable synchronizer. An edge detector turns the chosen edge into a one-cycle update pulse.

A module set up as the chain's master forwards the dedicated clock pin onto the second-highest I/O line. The other modules can then latch with low skew. The block sits between the host register file and the transceivers. The host register file supplies the control bits and the output word.

Top module: `dbs_sync_latch`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `line_out`, `in_word` and `master_clk_out` are all zero.
- R2: With `dbuf_en` = 0, the output holding register loads `out_word` on every falling edge of `clk`. `line_out` therefore shows a new `out_word` half a cycle after the rising edge that follows the change.
- R3: With `dbuf_en` = 0, `in_word` captures `line_in` on every rising edge of `clk`.
- R4: With `dbuf_en` = 1, the two registers hold their values until the selected external edge. When the source changes level before rising edge k, the output register loads between edges k+1 and k+2, and `in_word` loads at edge k+2. Each selected edge causes exactly one update.
- R5: `clk_pol` = 0 selects the rising edge of the external clock, and `clk_pol` = 1 selects the falling edge. The edge of the other direction has no effect on either register.
- R6: With `ms_mode` = 0, the external clock is `ext_clk_pin`, and activity on `line_in[23]` causes no update. With `ms_mode` = 1, the clock is `line_in[23]`, and activity on `ext_clk_pin` causes no update.
- R7: When `ms_mode` = 1 and `master_sel` = 1, `line_out[22]` and `master_clk_out` both follow `ext_clk_pin` combinationally. Otherwise `master_clk_out` = 0, and `line_out[22]` carries bit 22 of the output holding register.
- R8: A change of `dbuf_en`, `clk_pol` or `ms_mode` never creates an update pulse by itself. This holds even when the newly selected source or edge would look like an edge against the old history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| dbuf_en | input | 1 | 1 = update on the external clock edge, 0 = track the system clock |
| clk_pol | input | 1 | External edge select: 0 rising, 1 falling |
| ms_mode | input | 1 | 1 = take the external clock from line 24 (`line_in[23]`) |
| master_sel | input | 1 | With `ms_mode`, forward `ext_clk_pin` to line 23 |
| out_word | input | 24 | Internal output latch contents |
| line_in | input | 24 | Raw received line states |
| ext_clk_pin | input | 1 | Dedicated single-ended synchronizing clock |
| line_out | output | 24 | Data to the line drivers |
| in_word | output | 24 | Captured input word |
| master_clk_out | output | 1 | Re-driven clock in master mode, else 0 |

## Verification
The pulse and hold assertions assume that the chosen external clock is much slower than `clk`. Each level must stay stable for at least two system cycles, which a 1 MHz limit against 8 MHz guarantees. The bench holds every external level for four cycles.

The assertions also assume that the control bits change only away from a pending edge. The bench therefore changes configuration only after the synchronizer has settled. All inputs are driven two nanoseconds after a rising edge, so no input change falls on a sampling edge of either register.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  // Control bits that steer the update source; a change in any of them
  // re-primes the edge detector.
  typedef struct packed {
    logic dbuf_en;
    logic clk_pol;
    logic ms_mode;
  } dbs_cfg_t;
endpackage

// File: rtl/dbs_cfg_track.sv
module dbs_cfg_track
  import dbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dbs_cfg_t cfg_in,
  output logic     reload
);
  dbs_cfg_t cfg_q;
  logic     primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_in;
      primed_q <= 1'b1;
    end
  end

  // Reload on the first cycle out of reset and on any control change.
  assign reload = !primed_q || (cfg_q != cfg_in);
endmodule

// File: rtl/dbs_edge_sync.sv
module dbs_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_pin,
  input  logic src_line,
  input  logic use_line,
  input  logic pol_fall,
  input  logic reload,
  output logic strobe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic             src;
  logic [TOP:0]     sync_q;
  logic             hist_q;
  logic             edge_seen;

  assign src = use_line ? src_line : src_pin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else if (reload) begin
      // Fill the whole chain from the new source so no old level is
      // compared against it.
      sync_q <= {SYNC_STAGES{src}};
      hist_q <= src;
    end else begin
      sync_q <= {sync_q[TOP-1:0], src};
      hist_q <= sync_q[TOP];
    end
  end

  assign edge_seen = pol_fall ? (hist_q & ~sync_q[TOP]) : (~hist_q & sync_q[TOP]);
  assign strobe    = edge_seen & ~reload;

  // R8: a primed chain never reports an edge on the following cycle.
  a_r8_no_pulse_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !strobe);
  // R4: one update per edge, given a source far slower than clk.
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/dbs_out_stage.sv
module dbs_out_stage #(
  parameter int WIDTH       = 24,
  parameter int MASTER_LINE = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbuf_en,
  input  logic             strobe,
  input  logic [WIDTH-1:0] out_word,
  input  logic             master_active,
  input  logic             master_clk,
  output logic [WIDTH-1:0] line_out
);
  logic [WIDTH-1:0] held_q;
  logic             load;

  assign load = !dbuf_en || strobe;

  // Holding register works on the falling system edge; strobe is produced
  // by rising-edge logic and is stable across the falling edge.
  always_ff @(negedge clk) begin
    if (!rst_n)    held_q <= '0;
    else if (load) held_q <= out_word;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    if (i == MASTER_LINE) begin : g_fwd
      assign line_out[i] = master_active ? master_clk : held_q[i];
    end else begin : g_dat
      assign line_out[i] = held_q[i];
    end
  end

  // R2: bypass mode tracks the input word every falling edge.
  a_r2_track_falling: assert property (@(negedge clk) disable iff (!rst_n)
    !dbuf_en |=> held_q == $past(out_word));
  // R4: between selected edges the register holds.
  a_r4_out_hold: assert property (@(negedge clk) disable iff (!rst_n)
    (dbuf_en && !strobe) |=> $stable(held_q));
endmodule

// File: rtl/dbs_in_stage.sv
module dbs_in_stage #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbuf_en,
  input  logic             strobe,
  input  logic [WIDTH-1:0] line_in,
  output logic [WIDTH-1:0] in_word
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  in_word <= '0;
    else if (!dbuf_en || strobe) in_word <= line_in;
  end

  // R3: bypass mode captures the lines every rising edge.
  a_r3_track_rising: assert property (@(posedge clk) disable iff (!rst_n)
    !dbuf_en |=> in_word == $past(line_in));
  // R4: between selected edges the captured word holds.
  a_r4_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !strobe) |=> $stable(in_word));
endmodule

// File: rtl/dbs_sync_latch.sv
module dbs_sync_latch
  import dbs_pkg::*;
#(
  parameter int WIDTH        = 24,
  parameter int SYNC_STAGES  = 2,
  parameter int CLK_IN_LINE  = 23,
  parameter int CLK_OUT_LINE = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbuf_en,
  input  logic             clk_pol,
  input  logic             ms_mode,
  input  logic             master_sel,
  input  logic [WIDTH-1:0] out_word,
  input  logic [WIDTH-1:0] line_in,
  input  logic             ext_clk_pin,
  output logic [WIDTH-1:0] line_out,
  output logic [WIDTH-1:0] in_word,
  output logic             master_clk_out
);
  dbs_cfg_t cfg;
  logic     reload;
  logic     strobe;
  logic     master_active;

  assign cfg           = '{dbuf_en: dbuf_en, clk_pol: clk_pol, ms_mode: ms_mode};
  assign master_active = ms_mode & master_sel;
  // Re-drive is combinational so chained modules see minimal skew.
  assign master_clk_out = master_active & ext_clk_pin;

  dbs_cfg_track u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_in (cfg),
    .reload (reload)
  );

  dbs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_pin  (ext_clk_pin),
    .src_line (line_in[CLK_IN_LINE]),
    .use_line (ms_mode),
    .pol_fall (clk_pol),
    .reload   (reload),
    .strobe   (strobe)
  );

  dbs_out_stage #(.WIDTH(WIDTH), .MASTER_LINE(CLK_OUT_LINE)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbuf_en       (dbuf_en),
    .strobe        (strobe),
    .out_word      (out_word),
    .master_active (master_active),
    .master_clk    (ext_clk_pin),
    .line_out      (line_out)
  );

  dbs_in_stage #(.WIDTH(WIDTH)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbuf_en (dbuf_en),
    .strobe  (strobe),
    .line_in (line_in),
    .in_word (in_word)
  );

  // R7: forwarded clock on the line matches the dedicated output.
  a_r7_fwd_match: assert property (@(posedge clk) disable iff (!rst_n)
    master_active |-> (master_clk_out == line_out[CLK_OUT_LINE]));
  // R6: with the single-ended source, no update pulse without dbuf_en path.
  a_r6_no_strobe_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && $stable(ext_clk_pin) && $stable(line_in[CLK_IN_LINE]) && $past(strobe)) |-> !strobe);
endmodule

// File: tb/sim_dbs_sync_latch.sv
`timescale 1ns/1ps
module sim_dbs_sync_latch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbuf_en, clk_pol, ms_mode, master_sel, ext_clk_pin;
  logic [23:0] out_word, line_in, line_out, in_word;
  logic        master_clk_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] exp_out, exp_in;

  always #10 clk = ~clk;

  dbs_sync_latch u0 (
    .clk(clk), .rst_n(rst_n), .dbuf_en(dbuf_en), .clk_pol(clk_pol),
    .ms_mode(ms_mode), .master_sel(master_sel), .out_word(out_word),
    .line_in(line_in), .ext_clk_pin(ext_clk_pin), .line_out(line_out),
    .in_word(in_word), .master_clk_out(master_clk_out)
  );

  // {out_word, line_in} pairs for the system-clock tracking mode.
  localparam logic [47:0] VEC [6] = '{
    {24'h000000, 24'hFFFFFF},
    {24'hFFFFFF, 24'h000000},
    {24'hA5A5A5, 24'h5A5A5A},
    {24'h123456, 24'h654321},
    {24'h800001, 24'h7FFFFE},
    {24'h3C0F0F, 24'hC3F0F0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_both(input string req);
    #3;
    chk({req, " line_out"}, line_out, exp_out);
    chk({req, " in_word"}, in_word, exp_in);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; dbuf_en = 0; clk_pol = 0; ms_mode = 0; master_sel = 0;
    ext_clk_pin = 0; out_word = 24'h5555AA; line_in = 24'hAA5555;
    tick(3); #3;
    chk("R1 line_out", line_out, 24'h0);
    chk("R1 in_word", in_word, 24'h0);
    chk("R1 master_clk_out", {23'h0, master_clk_out}, 24'h0);
    tick(1); rst_n = 1; tick(2);

    // R2/R3: tracking mode, table walk
    foreach (VEC[i]) begin
      out_word = VEC[i][47:24]; line_in = VEC[i][23:0];
      tick(1);
      exp_out = VEC[i][47:24]; exp_in = VEC[i][23:0];
      chk_both("R2/R3 track");
    end

    // R4/R5: double buffered on rising external edge
    dbuf_en = 1; tick(4);
    out_word = 24'h111111; line_in = 24'h222222;
    tick(4); chk_both("R4 hold before edge");
    ext_clk_pin = 1; tick(4);
    exp_out = 24'h111111; exp_in = 24'h222222;
    chk_both("R4 R5 rising update");
    out_word = 24'h333333; line_in = 24'h444444;
    tick(4); chk_both("R4 single update per edge");
    ext_clk_pin = 0; tick(4); chk_both("R5 falling ignored pol0");
    clk_pol = 1; tick(4); chk_both("R8 polarity change");
    ext_clk_pin = 1; tick(4); chk_both("R5 rising ignored pol1");
    ext_clk_pin = 0; tick(4);
    exp_out = 24'h333333; exp_in = 24'h444444;
    chk_both("R5 falling update pol1");

    // R6: clock from line 24
    clk_pol = 0; ms_mode = 1; out_word = 24'h0F0F0F; line_in = 24'h606060;
    tick(4); chk_both("R8 mode change");
    ext_clk_pin = 1; tick(4); chk_both("R6 pin ignored in line mode");
    ext_clk_pin = 0; tick(4);
    line_in = 24'hE06060; tick(4);
    exp_out = 24'h0F0F0F; exp_in = 24'hE06060;
    chk_both("R6 line 24 rising update");

    // R8: switching source from high line to low pin with falling polarity
    clk_pol = 1; tick(4);
    out_word = 24'h777777; tick(4); chk_both("R8 pol change line source");
    ms_mode = 0; tick(4); chk_both("R8 source switch");

    // R7: master forwarding
    ms_mode = 1; master_sel = 1; ext_clk_pin = 1; #1;
    chk("R7 line_out[22] high", {23'h0, line_out[22]}, 24'h1);
    chk("R7 master_clk_out high", {23'h0, master_clk_out}, 24'h1);
    tick(4); ext_clk_pin = 0; #1;
    chk("R7 line_out[22] low", {23'h0, line_out[22]}, 24'h0);
    chk("R7 master_clk_out low", {23'h0, master_clk_out}, 24'h0);
    tick(4); ms_mode = 0; ext_clk_pin = 1; tick(4); #3;
    chk("R7 no forward without mode", {23'h0, master_clk_out}, 24'h0);
    chk("R7 line_out[22] from latch", {23'h0, line_out[22]}, {23'h0, exp_out[22]});
    chk("R7 whole word from latch", line_out, exp_out);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule